// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block owns the 64-bit base-address register that places the memory-mapped PCIe configuration window in the physical address map. Software writes the register through a narrow byte-lane configuration port. The block turns the register into a decoded window: an enable, a base address aligned to the window size, and a length selector for 256 MB, 128 MB or 64 MB. Any write whose enabled byte lanes land on one of the register's eight bytes causes the window to be recomputed.

A downstream address stream is compared against the decoded window. On a hit, the block splits the offset into bus, device, function and register numbers. The bus number is limited to the buses that the selected window size can reach. The fourth length code is reserved. Writing it does not stop the block. Instead it sets an error flag that stays set and blocks all hits until a later write brings in a valid length code.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads as the default base with the enable bit (bit 0) set and length code 00. The outputs show `win_en`=1, `win_base` equal to the default base, `win_len`=00 and `len_err`=0.
- R2: A config write changes a register byte only when its lane enable is set and that byte's config address (REG_OFS plus byte index) lies in the addressed port word. Register bits 25:3 and all bits at or above ADDR_W always read as zero. Readback on `cfg_rdata` follows `cfg_addr` without any clock.
- R3: The decoded outputs (`win_en`, `win_base`, `win_len`, `len_err`) take up a register write at the first rising edge after the edge that stores it. They change at no other time.
- R4: Length code (bits 2:1) 00 selects 256 MB and keeps base bits ADDR_W-1:28. Code 01 selects 128 MB and keeps bits ADDR_W-1:27. Code 10 selects 64 MB and keeps bits ADDR_W-1:26. All lower base bits read as zero on `win_base`.
- R5: With register bit 0 clear, `win_en` is 0 and `hit` never rises.
- R6: Length code 11 sets `len_err` and forces `win_en` to 0 while `win_base` and `win_len` keep their last valid values. The flag stays set until a write brings in a code other than 11, which clears it.
- R7: `hit` is 1 exactly when `acc_valid` is 1, `win_en` is 1, and `acc_addr` equals `win_base` on all bits the selected length keeps.
- R8: On a hit, the offset is `acc_addr` bits 27:0 with the bits at and above the length's low base bit cleared. The fields are bus = offset[27:20], device = [19:15], function = [14:12] and register = [11:0]. Every field is zero when there is no hit.
- R9: A write whose enabled lanes touch no register byte (all lane enables clear, or another port word) leaves the register and all decoded outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Byte address of the port word (write and readback) |
| cfg_be | input | PORT_BYTES | Byte lane enables of the write |
| cfg_wdata | input | 8*PORT_BYTES | Write data, lane j in bits 8j+7:8j |
| cfg_rdata | output | 8*PORT_BYTES | Register bytes visible at `cfg_addr`, zero elsewhere |
| acc_valid | input | 1 | Address to decode is valid |
| acc_addr | input | ADDR_W | Physical address to decode |
| win_en | output | 1 | Window active |
| win_base | output | ADDR_W | Aligned window base |
| win_len | output | 2 | Active length code (00 256 MB, 01 128 MB, 10 64 MB) |
| len_err | output | 1 | Sticky reserved-length flag |
| hit | output | 1 | Address falls in the window |
| hit_bus | output | 8 | Bus number of the hit |
| hit_dev | output | 5 | Device number of the hit |
| hit_func | output | 3 | Function number of the hit |
| hit_reg | output | 12 | Register byte offset of the hit |

## Verification
The bench builds the block with ADDR_W=32, an 8-bit config address, a 4-byte port and the register at byte 0x60. With these values the whole base field is only six bits (31:26), so every base value under every valid length code can be written. Each of those windows is probed with all 64 settings of the top address bits, which covers every alignment and bus-limit edge. The small port also makes every single-lane and mixed-lane write, and the upper register word that is reserved for this width, reachable in a handful of cycles.

// File: rtl/cfgwin_pkg.sv
// Package: shared types and constants for the configuration window decoder.
// Assumes the standard 28-bit offset layout of a 256-bus configuration window.
package cfgwin_pkg;

    // Length selector held in register bits 2:1; the order is behavioural.
    typedef enum logic [1:0] {
        LEN_256M = 2'b00,
        LEN_128M = 2'b01,
        LEN_64M  = 2'b10,
        LEN_RSVD = 2'b11
    } win_len_e;

    localparam int OFS_BITS    = 28;
    localparam int MIN_LOW_BIT = 26;
    localparam int REG_BYTES   = 8;
    localparam int BUS_W       = 8;
    localparam int DEV_W       = 5;
    localparam int FUNC_W      = 3;
    localparam int REGNO_W     = 12;

    // Decoded location inside the window.
    typedef struct packed {
        logic [BUS_W-1:0]   bus;
        logic [DEV_W-1:0]   dev;
        logic [FUNC_W-1:0]  func;
        logic [REGNO_W-1:0] regno;
    } cfg_loc_t;

    // Lowest base bit kept for a length code (reserved maps to the widest).
    function automatic int low_bit(win_len_e len);
        case (len)
            LEN_128M: return 27;
            LEN_64M:  return 26;
            default:  return 28;
        endcase
    endfunction

endpackage

// File: rtl/cfgwin_regbank.sv
// Module: byte-lane storage of the 64-bit window register.
// Maps each of the eight register bytes onto a config port word and lane,
// masks reserved bits on write and flags that a recompute is due.
// Assumes REG_OFS is 8-byte aligned and PORT_BYTES is a power of two <= 8.
module cfgwin_regbank
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W     = 40,
    parameter int          CFG_AW     = 12,
    parameter int          PORT_BYTES = 4,
    parameter int          REG_OFS    = 'h60,
    parameter logic [63:0] RST_BASE   = 64'h0000_0000_B000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CFG_AW-1:0]       addr,
    input  logic [PORT_BYTES-1:0]   be,
    input  logic [8*PORT_BYTES-1:0] wdata,
    output logic [8*PORT_BYTES-1:0] rdata,
    output logic [ADDR_W-1:0]       raw_win,
    output logic                    upd
);
    localparam int LANE_AW = (PORT_BYTES > 1) ? $clog2(PORT_BYTES) : 0;
    localparam int WORD_W  = CFG_AW - LANE_AW;
    localparam logic [63:0] ADDR_MASK = (ADDR_W >= 64) ? '1 : ((64'd1 << ADDR_W) - 64'd1);
    localparam logic [63:0] WMASK = (ADDR_MASK & ~((64'd1 << MIN_LOW_BIT) - 64'd1)) | 64'h7;
    localparam logic [63:0] RST_RAW = (RST_BASE & WMASK & ~64'h7) | 64'h1;

    logic [63:0]          raw_q;
    logic [63:0]          raw_nxt;
    logic [REG_BYTES-1:0] sel;
    logic [REG_BYTES-1:0] wr_byte;

    for (genvar k = 0; k < REG_BYTES; k++) begin : g_byte
        localparam int                 BA = REG_OFS + k;
        localparam int                 LN = BA % PORT_BYTES;
        localparam logic [WORD_W-1:0]  WD = WORD_W'(BA >> LANE_AW);
        assign sel[k]      = (addr[CFG_AW-1:LANE_AW] == WD);
        assign wr_byte[k]  = wr_en && sel[k] && be[LN];
        assign raw_nxt[8*k +: 8] = wr_byte[k] ? (wdata[8*LN +: 8] & WMASK[8*k +: 8])
                                              : raw_q[8*k +: 8];
    end

    // Store the register and note that a recompute is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= RST_RAW;
            upd   <= 1'b0;
        end else begin
            raw_q <= raw_nxt;
            upd   <= |wr_byte;
        end
    end

    // Return the register bytes that live in the addressed port word.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < REG_BYTES; k++) begin
            if (sel[k]) rdata[8*((REG_OFS + k) % PORT_BYTES) +: 8] = raw_q[8*k +: 8];
        end
    end

    assign raw_win = raw_q[ADDR_W-1:0];

    // R2: with no write strobe the stored register does not move.
    a_r2_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(raw_q));

endmodule

// File: rtl/cfgwin_decode.sv
// Module: turns the raw register into the decoded window state.
// Recomputes only when the register bank reports a write; a reserved length
// code raises a sticky error and blocks the window while the last valid
// base and length are kept. Assumes RST_BASE is 256 MB aligned.
module cfgwin_decode
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W   = 40,
    parameter logic [63:0] RST_BASE = 64'h0000_0000_B000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] raw,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_base,
    output win_len_e          win_len,
    output logic              len_err
);
    win_len_e code;

    // Base bits kept for a given length.
    function automatic logic [ADDR_W-1:0] base_mask(win_len_e len);
        logic [ADDR_W-1:0] m;
        m = '1;
        return m << low_bit(len);
    endfunction

    assign code = win_len_e'(raw[2:1]);

    // Recompute the window on a register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en   <= 1'b1;
            win_base <= RST_BASE[ADDR_W-1:0] & base_mask(LEN_256M);
            win_len  <= LEN_256M;
            len_err  <= 1'b0;
        end else if (upd) begin
            if (code == LEN_RSVD) begin
                len_err <= 1'b1;
                win_en  <= 1'b0;
            end else begin
                len_err  <= 1'b0;
                win_en   <= raw[0];
                win_len  <= code;
                win_base <= raw & base_mask(code);
            end
        end
    end

    // R3: without a pending update the decoded window is frozen.
    a_r3_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(win_en) && $stable(win_base) && $stable(win_len) && $stable(len_err)));

endmodule

// File: rtl/cfgwin_match.sv
// Module: compares an address to the decoded window and splits the offset.
// Purely combinational; the offset is cut to the window size so the bus
// number cannot exceed what the selected length reaches.
module cfgwin_match
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              win_en,
    input  logic [ADDR_W-1:0] win_base,
    input  win_len_e          win_len,
    output logic              hit,
    output cfg_loc_t          loc
);
    int                  lb;
    logic [ADDR_W-1:0]   cmp_mask;
    logic [OFS_BITS-1:0] ofs;

    // Match the kept base bits and cut the offset to the window.
    always_comb begin
        lb       = low_bit(win_len);
        cmp_mask = '1;
        cmp_mask = cmp_mask << lb;
        hit      = acc_valid && win_en && ((acc_addr & cmp_mask) == win_base);
        ofs      = acc_addr[OFS_BITS-1:0] & ((OFS_BITS'(1) << lb) - OFS_BITS'(1));
        loc      = '0;
        if (hit) loc = ofs;
    end

endmodule

// File: rtl/cfgwin_decoder.sv
// Module: top of the configuration window decoder.
// Chains the byte-lane register bank, the window decode stage and the
// address matcher. Assumes ADDR_W is between 29 and 64.
module cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W     = 40,
    parameter int          CFG_AW     = 12,
    parameter int          PORT_BYTES = 4,
    parameter int          REG_OFS    = 'h60,
    parameter logic [63:0] RST_BASE   = 64'h0000_0000_B000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr_en,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [PORT_BYTES-1:0]   cfg_be,
    input  logic [8*PORT_BYTES-1:0] cfg_wdata,
    output logic [8*PORT_BYTES-1:0] cfg_rdata,
    input  logic                    acc_valid,
    input  logic [ADDR_W-1:0]       acc_addr,
    output logic                    win_en,
    output logic [ADDR_W-1:0]       win_base,
    output logic [1:0]              win_len,
    output logic                    len_err,
    output logic                    hit,
    output logic [7:0]              hit_bus,
    output logic [4:0]              hit_dev,
    output logic [2:0]              hit_func,
    output logic [11:0]             hit_reg
);
    logic [ADDR_W-1:0] raw_win;
    logic              upd;
    win_len_e          len_q;
    cfg_loc_t          loc;

    cfgwin_regbank #(
        .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .PORT_BYTES(PORT_BYTES),
        .REG_OFS(REG_OFS), .RST_BASE(RST_BASE)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .be(cfg_be), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .raw_win(raw_win), .upd(upd)
    );

    cfgwin_decode #(.ADDR_W(ADDR_W), .RST_BASE(RST_BASE)) u_dec (
        .clk(clk), .rst_n(rst_n), .upd(upd), .raw(raw_win),
        .win_en(win_en), .win_base(win_base), .win_len(len_q), .len_err(len_err)
    );

    cfgwin_match #(.ADDR_W(ADDR_W)) u_match (
        .acc_valid(acc_valid), .acc_addr(acc_addr), .win_en(win_en),
        .win_base(win_base), .win_len(len_q), .hit(hit), .loc(loc)
    );

    assign win_len  = len_q;
    assign hit_bus  = loc.bus;
    assign hit_dev  = loc.dev;
    assign hit_func = loc.func;
    assign hit_reg  = loc.regno;

    // R5: a disabled window never reports a hit.
    a_r5_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> !hit);

    // R6: a pending reserved-length error blocks every hit.
    a_r6_err_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !hit);

    // R7: a hit needs a valid access.
    a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> acc_valid);

    // R8: fields stay zero without a hit.
    a_r8_idle_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_bus == '0 && hit_dev == '0 && hit_func == '0 && hit_reg == '0));

endmodule

// File: tb/cfgwin_decoder_test.sv
// Bench: exhaustive base/length sweep of a 32-bit build with arithmetic model.
module cfgwin_decoder_test;
    localparam int AW  = 32;
    localparam int CAW = 8;
    localparam int PB  = 4;
    localparam int OFS = 'h60;
    localparam logic [63:0] WM = 64'h0000_0000_FC00_0007;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr_en;
    logic [CAW-1:0] cfg_addr;
    logic [PB-1:0] cfg_be;
    logic [31:0]   cfg_wdata;
    logic [31:0]   cfg_rdata;
    logic          acc_valid;
    logic [AW-1:0] acc_addr;
    logic          win_en;
    logic [AW-1:0] win_base;
    logic [1:0]    win_len;
    logic          len_err;
    logic          hit;
    logic [7:0]    hit_bus;
    logic [4:0]    hit_dev;
    logic [2:0]    hit_func;
    logic [11:0]   hit_reg;

    always #10 clk = ~clk;

    cfgwin_decoder #(
        .ADDR_W(AW), .CFG_AW(CAW), .PORT_BYTES(PB), .REG_OFS(OFS),
        .RST_BASE(64'h0000_0000_B000_0000)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .win_en(win_en),
        .win_base(win_base), .win_len(win_len), .len_err(len_err), .hit(hit),
        .hit_bus(hit_bus), .hit_dev(hit_dev), .hit_func(hit_func), .hit_reg(hit_reg)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0]   m_raw;
    logic          m_en;
    logic [AW-1:0] m_base;
    logic [1:0]    m_len;
    logic          m_err;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_state();
        return {28'd0, m_en, m_len, m_err, m_base};
    endfunction

    function automatic logic [63:0] dut_state();
        return {28'd0, win_en, win_len, len_err, win_base};
    endfunction

    task automatic readback(input string tag);
        cfg_addr = CAW'(OFS); #1;
        chk(tag, {32'd0, cfg_rdata}, {32'd0, m_raw[31:0]});
        cfg_addr = CAW'(OFS + 4); #1;
        chk(tag, {32'd0, cfg_rdata}, {32'd0, m_raw[63:32]});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [3:0] be,
                            input logic [31:0] d, input string tag);
        logic [63:0] old;
        bit touched;
        touched = 1'b0;
        old = exp_state();
        for (int k = 0; k < 8; k++) begin
            if (((OFS + k) >> 2) == (int'(a) >> 2) && be[(OFS + k) % 4]) begin
                m_raw[8*k +: 8] = d[8*((OFS + k) % 4) +: 8] & WM[8*k +: 8];
                touched = 1'b1;
            end
        end
        if (touched) begin
            if (m_raw[2:1] == 2'b11) begin
                m_err = 1'b1; m_en = 1'b0;
            end else begin
                m_err  = 1'b0;
                m_en   = m_raw[0];
                m_len  = m_raw[2:1];
                m_base = m_raw[AW-1:0] & ~((32'd1 << (28 - int'(m_raw[2:1]))) - 32'd1);
            end
        end
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
        chk("R3 outputs before decode edge", dut_state(), old);
        @(negedge clk);
        chk({tag, " outputs after decode edge"}, dut_state(), exp_state());
        readback({tag, " readback"});
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic v);
        int lim;
        logic [27:0] off;
        logic exp_hit;
        acc_valid = v; acc_addr = a; #1;
        lim = 1 << (28 - int'(m_len));
        exp_hit = v && m_en && !m_err &&
                  ((a & ~(AW'(lim) - AW'(1))) == m_base);
        off = exp_hit ? 28'(int'(a[27:0]) % lim) : 28'd0;
        chk("R7 hit", {63'd0, hit}, {63'd0, exp_hit});
        chk("R8 fields", {36'd0, hit_bus, hit_dev, hit_func, hit_reg},
            {36'd0, off[27:20], off[19:15], off[14:12], off[11:0]});
        acc_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_be = '0;
        cfg_wdata = '0; acc_valid = 1'b0; acc_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_raw = 64'h0000_0000_B000_0001; m_en = 1'b1; m_base = 32'hB000_0000;
        m_len = 2'b00; m_err = 1'b0;
        // R1: reset state at the outputs and on readback.
        chk("R1 reset outputs", dut_state(), exp_state());
        readback("R1");
        probe(32'hB012_3456, 1'b1);
        probe(32'hC000_0000, 1'b1);
        probe(32'hB012_3456, 1'b0);
        // R9: writes that touch no register byte.
        do_write(8'h60, 4'b0000, 32'hFFFF_FFFF, "R9");
        do_write(8'h5C, 4'b1111, 32'hFFFF_FFFF, "R9");
        do_write(8'h68, 4'b1111, 32'h0000_0000, "R9");
        // R2: reserved upper word and single/mixed lanes.
        do_write(8'h64, 4'b1111, 32'hFFFF_FFFF, "R2");
        do_write(8'h60, 4'b1000, 32'hE5FF_FFFF, "R2");
        do_write(8'h60, 4'b0001, 32'hFFFF_FFFD, "R2");
        do_write(8'h60, 4'b0110, 32'hFFFF_FFFF, "R2");
        probe(32'hE7FF_FFFF, 1'b1);
        // R6: reserved code, still reserved, then cleared.
        do_write(8'h60, 4'b0001, 32'h0000_0007, "R6");
        probe(32'hE400_1000, 1'b1);
        do_write(8'h60, 4'b0001, 32'h0000_0006, "R6");
        do_write(8'h60, 4'b0001, 32'h0000_0001, "R6");
        probe(32'hE012_3000, 1'b1);
        // R5: enable cleared.
        do_write(8'h60, 4'b1111, 32'hE000_0000, "R5");
        probe(32'hE012_3000, 1'b1);
        // R4, R7, R8: every base under every valid length, every top-bit probe.
        for (int code = 0; code < 3; code++) begin
            for (int up = 0; up < 64; up++) begin
                do_write(8'h60, 4'b1111,
                         (32'(up) << 26) | (32'(code) << 1) | 32'd1, "R4");
                for (int p = 0; p < 64; p++) begin
                    probe((32'(p) << 26) |
                          32'(26'(p * 2654435 + up * 40503 + code * 977)), 1'b1);
                end
            end
        end
        probe(m_base, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule